// File: doc/BRIEF.md
# Command Completion Counter and Interrupt

This block is the per-channel status and interrupt logic of a multi-channel DMA engine. The descriptor engine sends it a one-cycle strobe each time a command event occurs. The block counts those events in a hardware-owned 6-bit "done" counter. Software acknowledges events by copying the done value it last read into a separate "processed" field of the same register. The number of outstanding events is the modulo-64 difference between the two counts. An event also sets an interrupt-active flag, and software clears that flag with the same write. The first event after a list is started reports that the list was loaded, not that a command finished. The block counts it like any other event, and software discounts it.

The interrupt output is level or pulse, chosen by a bit in a small configuration register. In level mode the line stays high while the flag is set or unacknowledged events remain. In pulse mode each qualifying event gives a one-cycle pulse. A software write can land in the same cycle as an event strobe. In that case the increment is kept and the flag stays set, so a later read shows the newer count and the interrupt is not lost. A synchronous cancel input clears both counts and the flag.

Both registers are reached through a plain, single-cycle register port. Writes take effect at the clock edge, and reads are combinational from the addressed register. The event strobe and the cancel input are plain control pins with no handshake.

Top module: `cmd_done_irq`

## Requirements
- R1: After asynchronous reset (rst_n low), the counter register and the configuration register both read 0, and irq_o is 0.
- R2: Each cycle with evt_i high and cancel_i low raises the done count (counter register bits 5:0) by one, modulo 64, so 63 is followed by 0.
- R3: The done field is read-only. A write to the counter register leaves bits 5:0 unchanged whatever the write data holds there.
- R4: A write to the counter register (byte address 0x018) loads the processed count from write data bits 21:16, and the value reads back in bits 21:16.
- R5: An event sets the interrupt-active flag (counter register bit 8). A counter-register write with bit 8 at zero clears the flag.
- R6: If an event and a counter-register write fall in the same cycle, the done count still advances, the flag is 1 afterwards, and the processed count takes the written value.
- R7: In level mode (configuration bit 28 = 1), irq_o equals "interrupt enabled" AND (flag set OR done ≠ processed). The comparison is modulo 64, so a processed count ahead of a wrapped done count still reads as pending.
- R8: In pulse mode (configuration bit 28 = 0), irq_o is high for exactly the one cycle after each qualifying event, and is low otherwise.
- R9: The interrupt is enabled only when configuration bit 29 is 1. While list_mode_i is 1, configuration bit 31 must also be 1. Events are counted whether or not the interrupt is enabled.
- R10: cancel_i clears the done count, the processed count and the flag. It takes priority over an event or a counter-register write in the same cycle, and the discarded event gives no pulse.
- R11: The configuration register at byte address 0x000 stores write-data bits 31, 29 and 28. These read back in place, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cancel_i | input | 1 | Synchronous channel cancel; clears both counts and the flag |
| list_mode_i | input | 1 | Channel is running a descriptor list |
| evt_i | input | 1 | One-cycle command event strobe from the descriptor engine |
| csr_wr_i | input | 1 | Register write enable |
| csr_addr_i | input | ADDR_W (12) | Register byte address |
| csr_wdata_i | input | DATA_W (32) | Register write data |
| csr_rdata_o | output | DATA_W (32) | Read data of the addressed register |
| irq_o | output | 1 | Channel interrupt line |

## Verification
The bench uses the default parameters: a 6-bit count, a 32-bit data path and a 12-bit address. With a 6-bit count, a wrap of the done counter takes only 64 events, so it is driven directly. The bench then acknowledges with a processed value that is numerically larger than the wrapped done value, which shows that pending events are detected modulo 64. The vector table covers a write and an event in the same cycle, and a cancel that coincides with both. It also covers level and pulse modes and list-mode gating of the enable. Directed steps cover configuration readback with all bits set and a reset in mid-operation.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

  // configuration register bit positions
  localparam int CFG_LIST_IEN_BIT = 31;
  localparam int CFG_IEN_BIT      = 29;
  localparam int CFG_LEVEL_BIT    = 28;

  // counter register field positions
  localparam int ST_DONE_LSB = 0;
  localparam int ST_ACT_BIT  = 8;
  localparam int ST_PROC_LSB = 16;

  // register byte offsets
  localparam int REG_CFG_OFS = 'h000;
  localparam int REG_CNT_OFS = 'h018;

  typedef struct packed {
    logic list_ien;
    logic ien;
    logic level;
  } irq_cfg_t;

endpackage

// File: rtl/cdi_csr_decode.sv
module cdi_csr_decode
  import cdi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  done_i,
  input  logic [CNT_W-1:0]  proc_i,
  input  logic              act_i,
  output irq_cfg_t          cfg_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  proc_wdata_o,
  output logic              act_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(REG_CFG_OFS);
  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(REG_CNT_OFS);

  logic     sel_cfg, sel_cnt;
  irq_cfg_t cfg_q;

  assign sel_cfg = (addr_i == CFG_ADDR);
  assign sel_cnt = (addr_i == CNT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_i && sel_cfg) begin
      cfg_q.list_ien <= wdata_i[CFG_LIST_IEN_BIT];
      cfg_q.ien      <= wdata_i[CFG_IEN_BIT];
      cfg_q.level    <= wdata_i[CFG_LEVEL_BIT];
    end
  end

  assign cfg_o        = cfg_q;
  assign cnt_wr_o     = wr_i && sel_cnt;
  assign proc_wdata_o = wdata_i[ST_PROC_LSB +: CNT_W];
  assign act_wdata_o  = wdata_i[ST_ACT_BIT];

  always_comb begin
    rdata_o = '0;
    if (sel_cfg) begin
      rdata_o[CFG_LIST_IEN_BIT] = cfg_q.list_ien;
      rdata_o[CFG_IEN_BIT]      = cfg_q.ien;
      rdata_o[CFG_LEVEL_BIT]    = cfg_q.level;
    end else if (sel_cnt) begin
      rdata_o[ST_DONE_LSB +: CNT_W] = done_i;
      rdata_o[ST_ACT_BIT]           = act_i;
      rdata_o[ST_PROC_LSB +: CNT_W] = proc_i;
    end
  end

endmodule

// File: rtl/cdi_counter_core.sv
module cdi_counter_core #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel_i,
  input  logic             evt_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] proc_wdata_i,
  input  logic             act_wdata_i,
  output logic [CNT_W-1:0] done_o,
  output logic [CNT_W-1:0] proc_o,
  output logic             act_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] done_q, proc_q;
  logic             act_q;

  // done count: hardware owned, software writes never touch it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= '0;
    else if (cancel_i) done_q <= '0;
    else if (evt_i)    done_q <= done_q + ONE;
  end

  // processed count: software owned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        proc_q <= '0;
    else if (cancel_i) proc_q <= '0;
    else if (cnt_wr_i) proc_q <= proc_wdata_i;
  end

  // interrupt-active flag: an event wins over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= 1'b0;
    else if (cancel_i) act_q <= 1'b0;
    else if (evt_i)    act_q <= 1'b1;
    else if (cnt_wr_i) act_q <= act_wdata_i;
  end

  assign done_o = done_q;
  assign proc_o = proc_q;
  assign act_o  = act_q;

endmodule

// File: rtl/cdi_irq_gen.sv
module cdi_irq_gen
  import cdi_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel_i,
  input  irq_cfg_t         cfg_i,
  input  logic             list_mode_i,
  input  logic             evt_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] done_i,
  input  logic [CNT_W-1:0] proc_i,
  output logic             irq_o
);

  logic enabled, pending, level_irq, pulse_q;

  assign enabled   = cfg_i.ien && (!list_mode_i || cfg_i.list_ien);
  // modulo difference is nonzero exactly when the counts differ
  assign pending   = (done_i - proc_i) != '0;
  assign level_irq = enabled && (act_i || pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= enabled && evt_i && !cancel_i;
  end

  assign irq_o = cfg_i.level ? level_irq : pulse_q;

endmodule

// File: rtl/cmd_done_irq.sv
module cmd_done_irq
  import cdi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cancel_i,
  input  logic              list_mode_i,
  input  logic              evt_i,
  input  logic              csr_wr_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  output logic              irq_o
);

  irq_cfg_t         cfg_w;
  logic             cnt_wr_w, act_wdata_w, act_w;
  logic [CNT_W-1:0] proc_wdata_w, done_w, proc_w;

  cdi_csr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (csr_wr_i),
    .addr_i       (csr_addr_i),
    .wdata_i      (csr_wdata_i),
    .done_i       (done_w),
    .proc_i       (proc_w),
    .act_i        (act_w),
    .cfg_o        (cfg_w),
    .cnt_wr_o     (cnt_wr_w),
    .proc_wdata_o (proc_wdata_w),
    .act_wdata_o  (act_wdata_w),
    .rdata_o      (csr_rdata_o)
  );

  cdi_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .cancel_i     (cancel_i),
    .evt_i        (evt_i),
    .cnt_wr_i     (cnt_wr_w),
    .proc_wdata_i (proc_wdata_w),
    .act_wdata_i  (act_wdata_w),
    .done_o       (done_w),
    .proc_o       (proc_w),
    .act_o        (act_w)
  );

  cdi_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cancel_i    (cancel_i),
    .cfg_i       (cfg_w),
    .list_mode_i (list_mode_i),
    .evt_i       (evt_i),
    .act_i       (act_w),
    .done_i      (done_w),
    .proc_i      (proc_w),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/cmd_done_irq_chk.sv
module cmd_done_irq_chk
  import cdi_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cancel_i,
  input logic             evt_i,
  input logic             list_mode_i,
  input logic             cnt_wr,
  input irq_cfg_t         cfg,
  input logic [CNT_W-1:0] done,
  input logic [CNT_W-1:0] proc,
  input logic             act,
  input logic             irq_o
);

  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !cancel_i) |=> (done == $past(done) + CNT_W'(1))); // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !cancel_i) |=> $stable(done)); // R3

  AST_RACE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && cnt_wr && !cancel_i) |=> act); // R6

  AST_CANCEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (done == '0 && proc == '0 && !act)); // R10

  AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.level && cfg.ien && !list_mode_i && act) |-> irq_o); // R7

  AST_NO_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.level && !cfg.ien) |-> !irq_o); // R9

endmodule

bind cmd_done_irq cmd_done_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cancel_i    (cancel_i),
  .evt_i       (evt_i),
  .list_mode_i (list_mode_i),
  .cnt_wr      (cnt_wr_w),
  .cfg         (cfg_w),
  .done        (done_w),
  .proc        (proc_w),
  .act         (act_w),
  .irq_o       (irq_o)
);

// File: tb/tb_cmd_done_irq.sv
module tb_cmd_done_irq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;
  localparam logic [11:0] A_CFG = 12'h000;
  localparam logic [11:0] A_CNT = 12'h018;

  // {wr, to_cfg, wdata[32], evt, list_mode, cancel, exp_cnt[32], exp_irq}
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b1,1'b1,32'h3000_0000,1'b0,1'b0,1'b0,32'h0000_0000,1'b0}, // R11 level+ien
    {1'b0,1'b0,32'h0,        1'b1,1'b0,1'b0,32'h0000_0101,1'b1}, // R2 R5 R7
    {1'b0,1'b0,32'h0,        1'b1,1'b0,1'b0,32'h0000_0102,1'b1}, // R2
    {1'b1,1'b0,32'h0002_0000,1'b0,1'b0,1'b0,32'h0002_0002,1'b0}, // R4 R5 R7 ack
    {1'b1,1'b0,32'h0002_003F,1'b0,1'b0,1'b0,32'h0002_0002,1'b0}, // R3 done read-only
    {1'b1,1'b0,32'h0002_0000,1'b1,1'b0,1'b0,32'h0002_0103,1'b1}, // R6 race
    {1'b1,1'b0,32'h0003_0000,1'b0,1'b0,1'b0,32'h0003_0003,1'b0}, // R4
    {1'b1,1'b0,32'h0001_0000,1'b0,1'b0,1'b0,32'h0001_0003,1'b1}, // R7 pending only
    {1'b1,1'b0,32'h0003_0000,1'b0,1'b0,1'b0,32'h0003_0003,1'b0}, // R7
    {1'b1,1'b1,32'h2000_0000,1'b0,1'b0,1'b0,32'h0003_0003,1'b0}, // R8 pulse mode
    {1'b0,1'b0,32'h0,        1'b1,1'b0,1'b0,32'h0003_0104,1'b1}, // R8 pulse
    {1'b0,1'b0,32'h0,        1'b0,1'b0,1'b0,32'h0003_0104,1'b0}, // R8 one cycle
    {1'b0,1'b0,32'h0,        1'b1,1'b1,1'b0,32'h0003_0105,1'b0}, // R9 list gated
    {1'b1,1'b1,32'hA000_0000,1'b0,1'b0,1'b0,32'h0003_0105,1'b0}, // R9 list enable
    {1'b0,1'b0,32'h0,        1'b1,1'b1,1'b0,32'h0003_0106,1'b1}, // R9
    {1'b0,1'b0,32'h0,        1'b0,1'b0,1'b1,32'h0000_0000,1'b0}, // R10
    {1'b1,1'b0,32'h0005_0100,1'b1,1'b0,1'b1,32'h0000_0000,1'b0}, // R10 priority
    {1'b1,1'b1,32'h1000_0000,1'b0,1'b0,1'b0,32'h0000_0000,1'b0}, // R9 ien off
    {1'b0,1'b0,32'h0,        1'b1,1'b0,1'b0,32'h0000_0101,1'b0}  // R9 counted, no irq
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cancel_i = 1'b0, list_mode_i = 1'b0, evt_i = 1'b0, csr_wr_i = 1'b0;
  logic [11:0] csr_addr_i = A_CNT;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_done_irq dut (
    .clk(clk), .rst_n(rst_n), .cancel_i(cancel_i), .list_mode_i(list_mode_i),
    .evt_i(evt_i), .csr_wr_i(csr_wr_i), .csr_addr_i(csr_addr_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    csr_wr_i = 1'b0; evt_i = 1'b0; cancel_i = 1'b0; list_mode_i = 1'b0;
    csr_addr_i = A_CNT; csr_wdata_i = '0;
  endtask

  // one cycle of stimulus; sampled just after the edge
  task automatic step(input logic wr, input logic to_cfg, input logic [31:0] wd,
                      input logic ev, input logic lm, input logic cx);
    @(negedge clk);
    csr_wr_i = wr; csr_addr_i = to_cfg ? A_CFG : A_CNT; csr_wdata_i = wd;
    evt_i = ev; list_mode_i = lm; cancel_i = cx;
    @(posedge clk);
    #1;
    idle_inputs();
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 cnt reg at reset", csr_rdata_o, 32'h0);
    check("R1 irq at reset", {31'b0, irq_o}, 32'h0);
    csr_addr_i = A_CFG; #1;
    check("R1 cfg reg at reset", csr_rdata_o, 32'h0);
    csr_addr_i = A_CNT;
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][69], VEC[i][68], VEC[i][67:36], VEC[i][35], VEC[i][34], VEC[i][33]);
      check($sformatf("vector %0d cnt (R2-R10 per table)", i), csr_rdata_o, VEC[i][32:1]);
      check($sformatf("vector %0d irq (R7/R8/R9 per table)", i), {31'b0, irq_o},
            {31'b0, VEC[i][0]});
    end

    // R2 wrap: done=1 now; level mode with enable
    step(1'b1, 1'b1, 32'h3000_0000, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 62; k++) step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R2 done reaches 63", csr_rdata_o, 32'h0000_013F);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R2 done wraps to 0", csr_rdata_o, 32'h0000_0100);
    check("R7 level irq after wrap", {31'b0, irq_o}, 32'h1);
    step(1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R7 ack after wrap clears irq", {31'b0, irq_o}, 32'h0);
    step(1'b1, 1'b0, 32'h003F_0000, 1'b0, 1'b0, 1'b0);
    check("R4 processed 63 readback", csr_rdata_o, 32'h003F_0000);
    check("R7 modulo pending raises irq", {31'b0, irq_o}, 32'h1);

    // R11 config readback with all bits written
    step(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    csr_addr_i = A_CFG; #1;
    check("R11 cfg readback", csr_rdata_o, 32'hB000_0000);
    csr_addr_i = A_CNT;

    // R1 reset in mid-operation
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 cnt after mid reset", csr_rdata_o, 32'h0);
    check("R1 irq after mid reset", {31'b0, irq_o}, 32'h0);
    csr_addr_i = A_CFG; #1;
    check("R1 cfg after mid reset", csr_rdata_o, 32'h0);
    csr_addr_i = A_CNT;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule